// File: doc/BRIEF.md
# Field-Patchable Compute Slice

This block is one slice of a specialised datapath. Its operators can be reprogrammed after the silicon is built. It has four parts: a rewritable constant register, a bitwise unit with a selectable operation, a comparator that can evaluate any of six relations, and a single adder/subtractor with a selectable mode. The connections between these units are fixed. Only the function of each unit and the constant value can change.

The configuration word is shifted in serially, most significant bit first, into a shadow register. A separate update strobe copies the shadow register into the live configuration, but only while the slice is idle. A computation is launched by `start` together with `in_valid`. The registered result, comparison bit and carry/borrow appear one cycle later, together with a one-cycle `res_valid` pulse. If the live configuration holds an encoding the hardware cannot implement, the slice raises a trap flag so that software can take over the work. The flag stays set until the next launch.

Top module: `patch_slice`

## Requirements
- R1: After reset, `result`, `cmp_out`, `carry_out`, `res_valid` and `exc_flag` are zero. The live configuration is all zeros, which selects AND, EQ unsigned, add, `op_b` as the second operand, the adder result, and a constant of 0.
- R2: While `scan_en` is high, each clock shifts `scan_in` into the shadow register, most significant bit first. After 41 shifts the word is laid out from bit 40 down as follows: constant [40:9], bitwise code [8:7], relation code [6:4], signed flag [3], subtract flag [2], constant-select flag [1], result-select flag [0].
- R3: `cfg_upd` copies the shadow register into the live configuration only in a cycle where `start` is low. An update in a cycle where `start` is high is dropped. Shifting alone never changes the live configuration.
- R4: A launch is a clock edge with `start` and `in_valid` both high. Outputs update at that edge and `res_valid` is high for exactly that one following cycle. `start` without `in_valid` changes no output.
- R5: The second operand of every unit is `op_b` when the constant-select flag is 0, and the constant register when it is 1.
- R6: The bitwise codes are 0 for AND, 1 for OR and 2 for XOR. `result` carries the bitwise output when the result-select flag is 1, and the adder output when it is 0.
- R7: With the subtract flag at 0, the adder produces (a+b) mod 2^32 and `carry_out` is the carry out. With the flag at 1, it produces (a-b) mod 2^32 and `carry_out` is the borrow, meaning a<b unsigned.
- R8: The relation codes are 0 EQ, 1 NE, 2 LT, 3 LE, 4 GT and 5 GE, comparing a against the second operand. When the signed flag is 1 the comparison is two's complement; otherwise it is unsigned. `cmp_out` is 1 when the relation holds.
- R9: A launch with bitwise code 3, or with relation code 6 or 7, sets `exc_flag`. It also forces `result`, `cmp_out` and `carry_out` to zero, regardless of the result-select flag.
- R10: `exc_flag` holds its value between launches and is re-evaluated only at the next launch.
- R11: Between launches, `result`, `cmp_out` and `carry_out` hold their last values. Configuration updates do not change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_en | input | 1 | Shift enable for the configuration chain |
| scan_in | input | 1 | Serial configuration data |
| cfg_upd | input | 1 | Copy shadow configuration to live configuration |
| start | input | 1 | Launch request; also marks the slice busy |
| in_valid | input | 1 | Operands valid qualifier |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| result | output | 32 | Registered adder or bitwise result |
| cmp_out | output | 1 | Registered comparison outcome |
| carry_out | output | 1 | Registered carry or borrow |
| res_valid | output | 1 | One-cycle pulse after a launch |
| exc_flag | output | 1 | Sticky trap flag for unimplementable configuration |

## Verification
A wrong bit in the shadow or live configuration shows up in the first launch that follows it. Depending on which field is wrong, the result takes the wrong operation, operand or mode, the comparison uses the wrong relation or signedness, or the trap flag goes wrong. In every case the effect is visible one cycle after that launch. An update that leaks through while `start` is high, or a shift that reaches the live configuration, is caught the same way: a launch under the expected old configuration returns a different value. A faulty hold path shows up as outputs that change, or a trap flag that clears, in cycles that contain no launch.

// File: rtl/patch_pkg.sv
package patch_pkg;

    typedef enum logic [1:0] {
        BW_AND = 2'd0,
        BW_OR  = 2'd1,
        BW_XOR = 2'd2,
        BW_BAD = 2'd3
    } bw_op_e;

    typedef enum logic [2:0] {
        REL_EQ   = 3'd0,
        REL_NE   = 3'd1,
        REL_LT   = 3'd2,
        REL_LE   = 3'd3,
        REL_GT   = 3'd4,
        REL_GE   = 3'd5,
        REL_RSV6 = 3'd6,
        REL_RSV7 = 3'd7
    } rel_e;

    localparam int unsigned CTRL_BITS = 9;

endpackage

// File: rtl/patch_scan_cfg.sv
module patch_scan_cfg #(
    parameter int unsigned W = 41
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         shift_in,
    input  logic         upd,
    input  logic         hold,
    output logic [W-1:0] cfg
);
    typedef struct packed {
        logic [W-1:0] sh;
        logic [W-1:0] live;
    } scan_st_t;

    scan_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.sh = {st_q.sh[W-2:0], shift_in};
        end
        if (upd && !hold) begin
            st_d.live = st_q.sh;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg = st_q.live;

    // R3: live configuration frozen while the slice is busy
    a_r3_hold_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(st_q.live));

    // R3: no update strobe, no change to live configuration
    a_r3_no_update_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(st_q.live));

    // R2: serial bit enters at the low end
    a_r2_shift_entry: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (st_q.sh[0] == $past(shift_in)));

endmodule

// File: rtl/patch_bitwise.sv
module patch_bitwise
    import patch_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  bw_op_e        op,
    output logic [DW-1:0] y,
    output logic          bad
);
    assign bad = (op == BW_BAD);

    for (genvar i = 0; i < DW; i++) begin : g_bit
        always_comb begin
            unique case (op)
                BW_AND:  y[i] = a[i] & b[i];
                BW_OR:   y[i] = a[i] | b[i];
                BW_XOR:  y[i] = a[i] ^ b[i];
                default: y[i] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/patch_compare.sv
module patch_compare
    import patch_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  rel_e          rel,
    input  logic          signed_mode,
    output logic          hit,
    output logic          bad
);
    logic [DW-1:0] a_adj, b_adj;
    logic          eq, lt;

    always_comb begin
        a_adj = a;
        b_adj = b;
        if (signed_mode) begin
            a_adj[DW-1] = ~a[DW-1];
            b_adj[DW-1] = ~b[DW-1];
        end
        eq  = (a_adj == b_adj);
        lt  = (a_adj < b_adj);
        bad = 1'b0;
        unique case (rel)
            REL_EQ: hit = eq;
            REL_NE: hit = !eq;
            REL_LT: hit = lt;
            REL_LE: hit = lt | eq;
            REL_GT: hit = !(lt | eq);
            REL_GE: hit = !lt;
            default: begin
                hit = 1'b0;
                bad = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/patch_addsub.sv
module patch_addsub #(
    parameter int unsigned DW = 32
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          sub,
    output logic [DW-1:0] y,
    output logic          cout
);
    logic [DW:0] sum;

    always_comb begin
        sum  = {1'b0, a} + {1'b0, (sub ? ~b : b)} + {{DW{1'b0}}, sub};
        y    = sum[DW-1:0];
        cout = sub ? !sum[DW] : sum[DW];
    end
endmodule

// File: rtl/patch_slice.sv
module patch_slice
    import patch_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scan_en,
    input  logic          scan_in,
    input  logic          cfg_upd,
    input  logic          start,
    input  logic          in_valid,
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    output logic [DW-1:0] result,
    output logic          cmp_out,
    output logic          carry_out,
    output logic          res_valid,
    output logic          exc_flag
);
    localparam int unsigned CW = DW + CTRL_BITS;

    typedef struct packed {
        logic [DW-1:0] res;
        logic          cmp;
        logic          carry;
        logic          vld;
        logic          exc;
    } out_st_t;

    logic [CW-1:0] cfg_vec;
    logic [DW-1:0] k_val, opnd2, bw_y, as_y;
    bw_op_e        bw_sel;
    rel_e          rel_sel;
    logic          sgn_sel, sub_sel, k_sel, r_sel;
    logic          bw_bad, rel_bad, rel_hit, as_cout, launch;
    out_st_t       st_d, st_q;

    patch_scan_cfg #(.W(CW)) u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (scan_en),
        .shift_in (scan_in),
        .upd      (cfg_upd),
        .hold     (start),
        .cfg      (cfg_vec)
    );

    assign k_val   = cfg_vec[CW-1 -: DW];
    assign bw_sel  = bw_op_e'(cfg_vec[8:7]);
    assign rel_sel = rel_e'(cfg_vec[6:4]);
    assign sgn_sel = cfg_vec[3];
    assign sub_sel = cfg_vec[2];
    assign k_sel   = cfg_vec[1];
    assign r_sel   = cfg_vec[0];
    assign opnd2   = k_sel ? k_val : op_b;
    assign launch  = start & in_valid;

    patch_bitwise #(.DW(DW)) u_bw (
        .a   (op_a),
        .b   (opnd2),
        .op  (bw_sel),
        .y   (bw_y),
        .bad (bw_bad)
    );

    patch_compare #(.DW(DW)) u_cmp (
        .a           (op_a),
        .b           (opnd2),
        .rel         (rel_sel),
        .signed_mode (sgn_sel),
        .hit         (rel_hit),
        .bad         (rel_bad)
    );

    patch_addsub #(.DW(DW)) u_as (
        .a    (op_a),
        .b    (opnd2),
        .sub  (sub_sel),
        .y    (as_y),
        .cout (as_cout)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = launch;
        if (launch) begin
            st_d.exc = bw_bad | rel_bad;
            if (bw_bad | rel_bad) begin
                st_d.res   = '0;
                st_d.cmp   = 1'b0;
                st_d.carry = 1'b0;
            end else begin
                st_d.res   = r_sel ? bw_y : as_y;
                st_d.cmp   = rel_hit;
                st_d.carry = as_cout;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result    = st_q.res;
    assign cmp_out   = st_q.cmp;
    assign carry_out = st_q.carry;
    assign res_valid = st_q.vld;
    assign exc_flag  = st_q.exc;

    a_r4_valid_after_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (start && in_valid) |=> res_valid);

    a_r4_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !(start && in_valid) |=> !res_valid);

    a_r9_bad_bitwise_traps: assert property (@(posedge clk) disable iff (!rst_n)
        (start && in_valid && bw_bad) |=> exc_flag);

    a_r9_trap_zeroes_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && exc_flag) |-> (result == '0 && !cmp_out && !carry_out));

    a_r10_exc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(start && in_valid) |=> $stable(exc_flag));

    a_r11_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(start && in_valid) |=> ($stable(result) && $stable(cmp_out) && $stable(carry_out)));

endmodule

// File: tb/patch_slice_tb.sv
module patch_slice_tb_top;
    localparam int unsigned DW = 32;
    localparam int unsigned CW = DW + 9;
    localparam time CLK_PERIOD = 10ns;
    localparam int unsigned WATCHDOG = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scan_en = 1'b0, scan_in = 1'b0, cfg_upd = 1'b0;
    logic          start = 1'b0, in_valid = 1'b0;
    logic [DW-1:0] op_a = '0, op_b = '0;
    logic [DW-1:0] result;
    logic          cmp_out, carry_out, res_valid, exc_flag;

    int unsigned total = 0, bad = 0, cyc = 0;
    bit finished = 1'b0;
    logic [CW-1:0] cfg_m = '0;
    logic [DW+2:0] last_exp = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    patch_slice #(.DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .scan_in(scan_in),
        .cfg_upd(cfg_upd), .start(start), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .result(result), .cmp_out(cmp_out),
        .carry_out(carry_out), .res_valid(res_valid), .exc_flag(exc_flag)
    );

    function automatic logic [CW-1:0] mk_cfg(logic [DW-1:0] k, int bw, int rel,
                                            bit sg, bit sb, bit ks, bit rs);
        return {k, 2'(bw), 3'(rel), sg, sb, ks, rs};
    endfunction

    // returns {exc, carry, cmp, res}
    function automatic logic [DW+2:0] model(logic [CW-1:0] c, logic [DW-1:0] a, logic [DW-1:0] b);
        logic [DW-1:0] k, b2, bwv, asv;
        logic [DW:0]   wide;
        logic          cy, hit, lt, eq;
        int            bw, rel;
        k   = c[CW-1:9];
        bw  = int'(c[8:7]);
        rel = int'(c[6:4]);
        b2  = c[1] ? k : b;
        if (bw == 3 || rel >= 6) return {1'b1, 1'b0, 1'b0, {DW{1'b0}}};
        bwv = (bw == 0) ? (a & b2) : (bw == 1) ? (a | b2) : (a ^ b2);
        if (c[2]) begin
            asv = a - b2;
            cy  = (a < b2);
        end else begin
            wide = {1'b0, a} + {1'b0, b2};
            asv  = wide[DW-1:0];
            cy   = wide[DW];
        end
        eq = (a == b2);
        lt = c[3] ? ($signed(a) < $signed(b2)) : (a < b2);
        case (rel)
            0: hit = eq;
            1: hit = !eq;
            2: hit = lt;
            3: hit = lt || eq;
            4: hit = !(lt || eq);
            default: hit = !lt;
        endcase
        return {1'b0, cy, hit, c[0] ? bwv : asv};
    endfunction

    task automatic chk(string tag, logic [DW+3:0] got, logic [DW+3:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic load_cfg(logic [CW-1:0] c, bit blocked);
        for (int i = CW - 1; i >= 0; i--) begin
            @(negedge clk);
            scan_en = 1'b1;
            scan_in = c[i];
        end
        @(negedge clk);
        scan_en = 1'b0;
        cfg_upd = 1'b1;
        start   = blocked;
        @(negedge clk);
        cfg_upd = 1'b0;
        start   = 1'b0;
        if (!blocked) cfg_m = c;
    endtask

    task automatic run_op(string tag, logic [DW-1:0] a, logic [DW-1:0] b);
        logic [DW+2:0] e;
        @(negedge clk);
        op_a = a; op_b = b; start = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        start = 1'b0; in_valid = 1'b0;
        e = model(cfg_m, a, b);
        last_exp = e;
        chk(tag, {res_valid, exc_flag, carry_out, cmp_out, result}, {1'b1, e});
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset outputs", {res_valid, exc_flag, carry_out, cmp_out, result}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: default configuration is add, EQ unsigned, op_b
        run_op("R1 default cfg add", 32'hFFFF_FFFF, 32'h0000_0002);
        run_op("R1 default cfg eq", 32'h1234, 32'h1234);

        // R4: valid pulse lasts one cycle, then R11 holds outputs
        @(negedge clk);
        chk("R4 valid pulse one cycle", {31'd0, res_valid, 4'd0}, '0);
        chk("R11 hold after launch", {1'b0, exc_flag, carry_out, cmp_out, result}, {1'b0, last_exp});

        // R4: start without in_valid ignored
        op_a = 32'hDEAD; op_b = 32'hBEEF; start = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        start = 1'b0;
        chk("R4 start without valid", {res_valid, exc_flag, carry_out, cmp_out, result}, {1'b0, last_exp});

        // R2 R5 R6: constant operand, XOR, bitwise result
        load_cfg(mk_cfg(32'h0F0F_00FF, 2, 0, 0, 0, 1, 1), 0);
        chk("R11 update keeps outputs", {res_valid, exc_flag, carry_out, cmp_out, result}, {1'b0, last_exp});
        run_op("R2 R5 R6 xor const", 32'hFFFF_0000, 32'h0);
        load_cfg(mk_cfg(32'h0, 1, 1, 0, 0, 0, 1), 0);
        run_op("R6 or", 32'hA000_0005, 32'h0500_0A00);
        load_cfg(mk_cfg(32'h0, 0, 2, 0, 0, 0, 1), 0);
        run_op("R6 and", 32'hF0F0_1234, 32'h0FF0_FF00);

        // R7: subtract with borrow and wrap
        load_cfg(mk_cfg(32'h5, 0, 2, 1, 1, 1, 0), 0);
        run_op("R7 sub borrow", 32'h3, 32'h0);
        run_op("R7 sub no borrow", 32'h9, 32'h0);

        // R8: signed vs unsigned with sign bit set
        load_cfg(mk_cfg(32'h0, 0, 2, 1, 0, 0, 0), 0);
        run_op("R8 signed lt", 32'h8000_0000, 32'h1);
        load_cfg(mk_cfg(32'h0, 0, 2, 0, 0, 0, 0), 0);
        run_op("R8 unsigned lt", 32'h8000_0000, 32'h1);
        for (int r = 0; r < 6; r++) begin
            load_cfg(mk_cfg(32'h0, 0, r, r[0], 0, 0, 0), 0);
            run_op("R8 relation sweep eq", 32'h77, 32'h77);
            run_op("R8 relation sweep ne", 32'hFFFF_FFF0, 32'h10);
        end

        // R3: update while start high is dropped
        load_cfg(mk_cfg(32'h0, 0, 5, 0, 0, 0, 0), 0);
        load_cfg(mk_cfg(32'h0, 2, 0, 0, 1, 0, 1), 1);
        run_op("R3 busy update dropped", 32'h10, 32'h20);
        // R3: shifting alone never reaches live configuration
        for (int i = 0; i < CW; i++) begin
            @(negedge clk);
            scan_en = 1'b1;
            scan_in = 1'b1;
        end
        @(negedge clk);
        scan_en = 1'b0;
        run_op("R3 shift without update", 32'h30, 32'h20);

        // R9: illegal bitwise code, illegal relations
        load_cfg(mk_cfg(32'h0, 3, 0, 0, 0, 0, 0), 0);
        run_op("R9 bitwise code 3", 32'hFFFF_FFFF, 32'h1);
        repeat (3) @(negedge clk);
        chk("R10 exc sticky", {1'b0, exc_flag, carry_out, cmp_out, result}, {1'b0, 1'b1, 2'b0, 32'h0});
        load_cfg(mk_cfg(32'h0, 0, 6, 0, 0, 0, 1), 0);
        run_op("R9 relation 6", 32'h1, 32'h1);
        load_cfg(mk_cfg(32'h0, 0, 7, 1, 1, 0, 0), 0);
        run_op("R9 relation 7", 32'h5, 32'h1);
        load_cfg(mk_cfg(32'h0, 1, 4, 0, 0, 0, 0), 0);
        run_op("R10 exc cleared by legal launch", 32'h5, 32'h1);

        // random legal configurations and operands
        for (int n = 0; n < 30; n++) begin
            load_cfg(mk_cfg($urandom, $urandom % 3, $urandom % 6, 1'($urandom),
                            1'($urandom), 1'($urandom), 1'($urandom)), 0);
            for (int m = 0; m < 8; m++) begin
                run_op("R5 R6 R7 R8 random", $urandom, (m == 0) ? op_a : $urandom);
            end
        end
        finish_run();
    end
endmodule